// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers up to twenty-four interrupt sources, not counting reset, and turns them into one request with a 16-bit vector address for the processor. Two of the sources come from the processor itself as level requests: a software trap and an undefined-opcode trap. These have no latch. The other twenty-two arrive as single-cycle pulses and are held in per-source pending latches. Two of the latched sources cannot be masked. The remaining twenty pass only when a global master enable and their own enable bit are both set. One external pin source also needs a separate pin-enable bit.

Every cycle a fixed-order arbiter picks the most urgent eligible source. The block registers the request flag and the vector for the processor. When the processor accepts, the chosen latch is cleared, the master enable is saved and then cleared, and the vector stays frozen for one cycle. A return strobe restores the saved master enable. Nesting therefore happens only when a handler sets the master enable again.

Top module: `irqc_top`

## Requirements
- R1: A one-cycle pulse on `req_i[n]` for n in 2..23 sets pending latch n at the next clock edge. The latch stays set until it is accepted or cleared by software. Reset clears all latches, drops `irq_o` and sets `vec_o` to 0x0000.
- R2: If a pulse on `req_i[n]` arrives in the same cycle that latch n is cleared, by acceptance or by the software clear, the latch stays set.
- R3: With `clr_we_i` high, each 1 in `clr_mask_i[n]` (n in 2..23) clears pending latch n at the next edge. Other latches are untouched.
- R4: Source n in 4..23 is eligible only when the master enable and enable bit `en_wd_i[n]` are both 1. The master enable is written through `mie_we_i`/`mie_wd_i`, and all enable bits are written together through `en_we_i`.
- R5: Source 4 is also eligible only when the pin-enable bit (written through `pin_we_i`/`pin_wd_i`) is 1.
- R6: The non-maskable sources ignore the master enable and the enable bits. They are the processor level requests `req_i[0]` (software trap) and `req_i[1]` (undefined opcode), and latches 2 and 3.
- R7: Fixed order, most urgent first: `req_i[0]`, `req_i[1]`, latch 2, latch 3, then latches 4..23 with the lower index winning. Exactly one source is chosen.
- R8: The vector is 0xFFFC for sources 0 and 1, and 0xFFFE − 2·n for n in 2..15 (source 2 gives 0xFFFA, source 15 gives 0xFFE0). For n in 16..23 it is 0xFFBE − 2·(n−16).
- R9: `irq_o`/`vec_o` are registered from the arbitration one edge after the pending state. A latched pulse therefore shows after two edges, and a processor level request after one. `ack_i` while `irq_o` is 1 clears the chosen latch and drops `irq_o` at the next edge. `ack_i` while `irq_o` is 0 has no effect.
- R10: An accepted interrupt copies the master enable into a saved bit and clears the master enable. A `reti_i` strobe restores the master enable from the saved bit. In the same cycle, acceptance overrides a master-enable write, and a write overrides `reti_i`.
- R11: `vec_o` is unchanged in the cycle after acceptance. It also holds its last value while nothing is eligible.
- R12: When a handler sets the master enable again, a pending enabled maskable source is presented and can be accepted while the first is still being serviced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 24 | Bits 0/1: processor trap levels; bits 2..23: request pulses |
| mie_we_i | input | 1 | Master enable write strobe |
| mie_wd_i | input | 1 | Master enable write value |
| en_we_i | input | 1 | Enable bits write strobe |
| en_wd_i | input | 20 | Enable bits for sources 23..4 |
| pin_we_i | input | 1 | Pin-enable write strobe |
| pin_wd_i | input | 1 | Pin-enable value for source 4 |
| clr_we_i | input | 1 | Software latch clear strobe |
| clr_mask_i | input | 22 | Latches 23..2 to clear |
| ack_i | input | 1 | One-cycle acceptance from the processor |
| reti_i | input | 1 | Return-from-interrupt strobe |
| irq_o | output | 1 | Interrupt request to the processor |
| vec_o | output | 16 | Vector address of the presented source |

## Verification
The assertions take two things for granted. `ack_i` is a single-cycle strobe raised only while `irq_o` is 1. The processor drops its trap level on `req_i[1:0]` in the cycle after it accepts that trap. The bench drives `ack_i` only from its accept task, for one cycle, and releases the trap levels at the same moment. Its single deliberate acknowledge with no request pending checks that such an acknowledge is ignored. All inputs change on the falling edge. Request pulses last exactly one cycle, so no latch sees an ambiguous set or clear.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    // Vector address of source idx.
    // Sources below first_latch share one slot just under the top vector.
    // Latched sources step down by 2 from the top until jump_idx.
    // From jump_idx onwards they restart at jump_base.
    function automatic logic [15:0] vector_of(
        input int unsigned idx,
        input int unsigned first_latch,
        input int unsigned jump_idx,
        input logic [15:0] top_vec,
        input logic [15:0] jump_base
    );
        logic [15:0] v;
        if (idx < first_latch)
            v = top_vec - 16'd2;
        else if (idx < jump_idx)
            v = top_vec - 16'(2 * idx);
        else
            v = jump_base - 16'(2 * (idx - jump_idx));
        return v;
    endfunction

endpackage

// File: rtl/irqc_latch_bank.sv
module irqc_latch_bank #(
    parameter int unsigned NUM_SRC     = 24,
    parameter int unsigned FIRST_LATCH = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_SRC-1:FIRST_LATCH]   set_i,
    input  logic [NUM_SRC-1:FIRST_LATCH]   sw_clr_i,
    input  logic [NUM_SRC-1:FIRST_LATCH]   ack_clr_i,
    output logic [NUM_SRC-1:FIRST_LATCH]   pend_o
);
    localparam int unsigned LW = NUM_SRC - FIRST_LATCH;

    typedef struct packed {
        logic [LW-1:0] pend;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // set dominates both kinds of clear
        st_d.pend = (st_q.pend & ~sw_clr_i & ~ack_clr_i) | set_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.pend;

    // R2
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((pend_o & $past(set_i)) == $past(set_i)));

    // R9
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|ack_clr_i) && ((set_i & ack_clr_i) == '0))
        |=> ((pend_o & $past(ack_clr_i)) == '0));

endmodule

// File: rtl/irqc_enable_regs.sv
module irqc_enable_regs #(
    parameter int unsigned NUM_SRC    = 24,
    parameter int unsigned FIRST_MASK = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          mie_we_i,
    input  logic                          mie_wd_i,
    input  logic                          en_we_i,
    input  logic [NUM_SRC-1:FIRST_MASK]   en_wd_i,
    input  logic                          pin_we_i,
    input  logic                          pin_wd_i,
    input  logic                          take_i,
    input  logic                          reti_i,
    output logic                          mie_o,
    output logic                          pin_o,
    output logic [NUM_SRC-1:FIRST_MASK]   en_o
);
    localparam int unsigned EW = NUM_SRC - FIRST_MASK;

    typedef struct packed {
        logic          mie;
        logic          saved;
        logic          pin;
        logic [EW-1:0] en;
    } ctl_t;

    ctl_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (en_we_i)  st_d.en  = en_wd_i;
        if (pin_we_i) st_d.pin = pin_wd_i;
        // master enable: acceptance > software write > return strobe
        if (take_i) begin
            st_d.saved = st_q.mie;
            st_d.mie   = 1'b0;
        end else if (mie_we_i) begin
            st_d.mie = mie_wd_i;
        end else if (reti_i) begin
            st_d.mie = st_q.saved;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mie_o = st_q.mie;
    assign pin_o = st_q.pin;
    assign en_o  = st_q.en;

    // R10
    ack_drops_mie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |=> !mie_o);

    // R10
    ack_saves_mie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |=> (st_q.saved == $past(mie_o)));

endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter #(
    parameter int unsigned NUM_SRC     = 24,
    parameter int unsigned FIRST_LATCH = 2,
    parameter int unsigned FIRST_MASK  = 4,
    parameter int unsigned PIN_SRC     = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [FIRST_LATCH-1:0]        cpu_req_i,
    input  logic [NUM_SRC-1:FIRST_LATCH]  pend_i,
    input  logic                          mie_i,
    input  logic                          pin_i,
    input  logic [NUM_SRC-1:FIRST_MASK]   en_i,
    output logic [NUM_SRC-1:0]            grant_o,
    output logic                          any_o
);
    logic [NUM_SRC-1:0] cand;

    for (genvar k = 0; k < NUM_SRC; k++) begin : g_cand
        if (k < FIRST_LATCH) begin : g_cpu
            assign cand[k] = cpu_req_i[k];
        end else if (k < FIRST_MASK) begin : g_nmi
            assign cand[k] = pend_i[k];
        end else if (k == PIN_SRC) begin : g_pin
            assign cand[k] = pend_i[k] & en_i[k] & mie_i & pin_i;
        end else begin : g_mask
            assign cand[k] = pend_i[k] & en_i[k] & mie_i;
        end
    end

    always_comb begin
        logic found;
        found   = 1'b0;
        grant_o = '0;
        for (int k = 0; k < int'(NUM_SRC); k++) begin
            if (cand[k] && !found) begin
                grant_o[k] = 1'b1;
                found      = 1'b1;
            end
        end
        any_o = found;
    end

    // R7
    single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_o |-> $onehot(grant_o));

    // R4
    mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mie_i |-> (grant_o[NUM_SRC-1:FIRST_MASK] == '0));

endmodule

// File: rtl/irqc_vec_enc.sv
module irqc_vec_enc #(
    parameter int unsigned NUM_SRC     = 24,
    parameter int unsigned FIRST_LATCH = 2,
    parameter int unsigned JUMP_SRC    = 16,
    parameter logic [15:0] VEC_TOP     = 16'hFFFE,
    parameter logic [15:0] VEC_JUMP    = 16'hFFBE
) (
    input  logic [NUM_SRC-1:0] grant_i,
    output logic [15:0]        vec_o
);
    always_comb begin
        vec_o = '0;
        for (int k = 0; k < int'(NUM_SRC); k++) begin
            if (grant_i[k])
                vec_o = vec_o | irqc_pkg::vector_of(unsigned'(k), FIRST_LATCH,
                                                    JUMP_SRC, VEC_TOP, VEC_JUMP);
        end
    end
endmodule

// File: rtl/irqc_top.sv
module irqc_top #(
    parameter int unsigned NUM_SRC     = 24,
    parameter int unsigned CPU_SRC     = 2,
    parameter int unsigned NMI_LATCHED = 2,
    parameter int unsigned PIN_SRC     = 4,
    parameter int unsigned JUMP_SRC    = 16,
    parameter logic [15:0] VEC_TOP     = 16'hFFFE,
    parameter logic [15:0] VEC_JUMP    = 16'hFFBE
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic [NUM_SRC-1:0]                      req_i,
    input  logic                                    mie_we_i,
    input  logic                                    mie_wd_i,
    input  logic                                    en_we_i,
    input  logic [NUM_SRC-1:CPU_SRC+NMI_LATCHED]    en_wd_i,
    input  logic                                    pin_we_i,
    input  logic                                    pin_wd_i,
    input  logic                                    clr_we_i,
    input  logic [NUM_SRC-1:CPU_SRC]                clr_mask_i,
    input  logic                                    ack_i,
    input  logic                                    reti_i,
    output logic                                    irq_o,
    output logic [15:0]                             vec_o
);
    localparam int unsigned FIRST_LATCH = CPU_SRC;
    localparam int unsigned FIRST_MASK  = CPU_SRC + NMI_LATCHED;
    localparam int unsigned LW          = NUM_SRC - FIRST_LATCH;

    typedef struct packed {
        logic          irq;
        logic [15:0]   vec;
        logic [LW-1:0] sel;
    } pres_t;

    pres_t pres_d, pres_q;

    logic [NUM_SRC-1:FIRST_LATCH] pend_w, sw_clr_w, ack_clr_w;
    logic [NUM_SRC-1:FIRST_MASK]  en_w;
    logic [NUM_SRC-1:0]           grant_w;
    logic                         any_w, mie_w, pin_w, take;
    logic [15:0]                  enc_vec;

    assign take      = ack_i & pres_q.irq;
    assign sw_clr_w  = clr_we_i ? clr_mask_i : '0;
    assign ack_clr_w = take ? pres_q.sel : '0;

    irqc_latch_bank #(.NUM_SRC(NUM_SRC), .FIRST_LATCH(FIRST_LATCH)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (req_i[NUM_SRC-1:FIRST_LATCH]),
        .sw_clr_i  (sw_clr_w),
        .ack_clr_i (ack_clr_w),
        .pend_o    (pend_w)
    );

    irqc_enable_regs #(.NUM_SRC(NUM_SRC), .FIRST_MASK(FIRST_MASK)) u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .mie_we_i (mie_we_i),
        .mie_wd_i (mie_wd_i),
        .en_we_i  (en_we_i),
        .en_wd_i  (en_wd_i),
        .pin_we_i (pin_we_i),
        .pin_wd_i (pin_wd_i),
        .take_i   (take),
        .reti_i   (reti_i),
        .mie_o    (mie_w),
        .pin_o    (pin_w),
        .en_o     (en_w)
    );

    irqc_arbiter #(
        .NUM_SRC(NUM_SRC), .FIRST_LATCH(FIRST_LATCH),
        .FIRST_MASK(FIRST_MASK), .PIN_SRC(PIN_SRC)
    ) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_req_i (req_i[FIRST_LATCH-1:0]),
        .pend_i    (pend_w),
        .mie_i     (mie_w),
        .pin_i     (pin_w),
        .en_i      (en_w),
        .grant_o   (grant_w),
        .any_o     (any_w)
    );

    irqc_vec_enc #(
        .NUM_SRC(NUM_SRC), .FIRST_LATCH(FIRST_LATCH), .JUMP_SRC(JUMP_SRC),
        .VEC_TOP(VEC_TOP), .VEC_JUMP(VEC_JUMP)
    ) u_enc (
        .grant_i (grant_w),
        .vec_o   (enc_vec)
    );

    always_comb begin
        pres_d = pres_q;
        if (take) begin
            // freeze the vector for one cycle while latches settle
            pres_d.irq = 1'b0;
            pres_d.sel = '0;
        end else if (any_w) begin
            pres_d.irq = 1'b1;
            pres_d.vec = enc_vec;
            pres_d.sel = grant_w[NUM_SRC-1:FIRST_LATCH];
        end else begin
            pres_d.irq = 1'b0;
            pres_d.sel = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pres_q <= '0;
        else        pres_q <= pres_d;
    end

    assign irq_o = pres_q.irq;
    assign vec_o = pres_q.vec;

    // R11
    vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> ($stable(vec_o) && !irq_o));

    // R6
    nmi_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_w[FIRST_LATCH] && !take) |=> irq_o);

endmodule

// File: tb/irqc_top_test.sv
module irqc_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] req = '0;
    logic        mie_we = 0, mie_wd = 0, en_we = 0, pin_we = 0, pin_wd = 0;
    logic [23:4] en_wd = '0;
    logic        clr_we = 0;
    logic [23:2] clr_mask = '0;
    logic        ack = 0, reti = 0;
    logic        irq;
    logic [15:0] vec;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    irqc_top uut (
        .clk(clk), .rst_n(rst_n), .req_i(req),
        .mie_we_i(mie_we), .mie_wd_i(mie_wd),
        .en_we_i(en_we), .en_wd_i(en_wd),
        .pin_we_i(pin_we), .pin_wd_i(pin_wd),
        .clr_we_i(clr_we), .clr_mask_i(clr_mask),
        .ack_i(ack), .reti_i(reti),
        .irq_o(irq), .vec_o(vec)
    );

    function automatic logic [15:0] exp_vec(input int n);
        if (n < 2)       return 16'hFFFC;
        else if (n < 16) return 16'hFFFE - 16'(2 * n);
        else             return 16'hFFBE - 16'(2 * (n - 16));
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 0; req = '0; mie_we = 0; en_we = 0; pin_we = 0;
        clr_we = 0; ack = 0; reti = 0;
        tick(3);
        rst_n = 1;
        tick(1);
    endtask

    task automatic set_ctl(input logic m, input logic [23:4] e, input logic p);
        mie_we = 1; mie_wd = m; en_we = 1; en_wd = e; pin_we = 1; pin_wd = p;
        tick(1);
        mie_we = 0; en_we = 0; pin_we = 0;
    endtask

    task automatic write_mie(input logic m);
        mie_we = 1; mie_wd = m;
        tick(1);
        mie_we = 0;
    endtask

    task automatic pulse(input logic [23:0] bits);
        req = bits;
        tick(1);
        req = '0;
    endtask

    task automatic accept();
        ack = 1;
        tick(1);
        ack = 0;
        req[1:0] = 2'b00;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 reset irq", 32'(irq), 0);
        check("R1 reset vec", 32'(vec), 0);
        tick(3);
        check("R1 idle irq", 32'(irq), 0);
    endtask

    task automatic t_map();
        for (int n = 2; n < 24; n++) begin
            logic [15:0] held;
            do_reset();
            set_ctl(1'b1, '1, 1'b1);
            pulse(24'(1) << n);
            check("R9 not yet", 32'(irq), 0);
            tick(1);
            check($sformatf("R8 irq src %0d", n), 32'(irq), 1);
            check($sformatf("R8 vec src %0d", n), 32'(vec), 32'(exp_vec(n)));
            held = vec;
            accept();
            check("R9 irq after ack", 32'(irq), 0);
            check("R11 vec held after ack", 32'(vec), 32'(held));
            tick(3);
            check("R11 vec held idle", 32'(vec), 32'(held));
            check("R9 latch cleared", 32'(irq), 0);
        end
    endtask

    task automatic t_mask();
        do_reset();
        set_ctl(1'b0, '1, 1'b1);
        pulse(24'(1) << 10);
        tick(2);
        check("R4 master off", 32'(irq), 0);
        write_mie(1'b1);
        tick(1);
        check("R4 master on irq", 32'(irq), 1);
        check("R4 master on vec", 32'(vec), 32'(exp_vec(10)));
        accept();
        do_reset();
        set_ctl(1'b1, ~(20'(1) << 8), 1'b1);
        pulse(24'(1) << 12);
        tick(2);
        check("R4 own enable off", 32'(irq), 0);
    endtask

    task automatic t_pin();
        do_reset();
        set_ctl(1'b1, '1, 1'b0);
        pulse(24'(1) << 4);
        tick(2);
        check("R5 pin off", 32'(irq), 0);
        set_ctl(1'b1, '1, 1'b1);
        tick(1);
        check("R5 pin on vec", 32'(vec), 32'(exp_vec(4)));
        check("R5 pin on irq", 32'(irq), 1);
    endtask

    task automatic t_nmi();
        do_reset();
        pulse(24'(1) << 3);
        tick(1);
        check("R6 latch3 ignores masks", 32'(irq), 1);
        check("R6 latch3 vec", 32'(vec), 32'(exp_vec(3)));
        accept();
        tick(1);
        req[1] = 1'b1;
        tick(1);
        check("R9 level trap after one edge", 32'(irq), 1);
        check("R6 undef vec", 32'(vec), 32'hFFFC);
        accept();
        tick(1);
        check("R6 undef served", 32'(irq), 0);
    endtask

    task automatic t_prio();
        do_reset();
        set_ctl(1'b1, '1, 1'b1);
        pulse((24'(1) << 2) | (24'(1) << 3) | (24'(1) << 9) | (24'(1) << 17));
        req[0] = 1'b1;
        tick(1);
        check("R7 sw trap first", 32'(vec), 32'hFFFC);
        accept();
        tick(1);
        check("R7 latch2 next", 32'(vec), 32'(exp_vec(2)));
        accept();
        tick(1);
        check("R7 latch3 next", 32'(vec), 32'(exp_vec(3)));
        accept();
        tick(1);
        check("R10 masked after ack", 32'(irq), 0);
        write_mie(1'b1);
        tick(1);
        check("R7 lower index maskable", 32'(vec), 32'(exp_vec(9)));
        accept();
        write_mie(1'b1);
        tick(1);
        check("R7 remaining maskable", 32'(vec), 32'(exp_vec(17)));
        do_reset();
        set_ctl(1'b1, '1, 1'b1);
        pulse((24'(1) << 20) | (24'(1) << 6));
        tick(1);
        check("R7 6 beats 20", 32'(vec), 32'(exp_vec(6)));
    endtask

    task automatic t_swclr();
        do_reset();
        pulse((24'(1) << 7) | (24'(1) << 8));
        clr_we = 1; clr_mask = 22'(1) << (7 - 2);
        tick(1);
        clr_we = 0;
        set_ctl(1'b1, '1, 1'b1);
        tick(1);
        check("R3 cleared latch skipped", 32'(vec), 32'(exp_vec(8)));
        accept();
        tick(2);
        check("R3 nothing left", 32'(irq), 0);
    endtask

    task automatic t_setwins();
        do_reset();
        pulse(24'(1) << 3);
        tick(1);
        check("R2 first present", 32'(vec), 32'(exp_vec(3)));
        ack = 1; req[3] = 1;
        tick(1);
        ack = 0; req = '0;
        tick(1);
        check("R2 set beats ack clear", 32'(irq), 1);
        check("R2 set beats ack vec", 32'(vec), 32'(exp_vec(3)));
        do_reset();
        pulse(24'(1) << 5);
        clr_we = 1; clr_mask = 22'(1) << (5 - 2); req[5] = 1;
        tick(1);
        clr_we = 0; req = '0;
        set_ctl(1'b1, '1, 1'b1);
        tick(1);
        check("R2 set beats sw clear", 32'(vec), 32'(exp_vec(5)));
    endtask

    task automatic t_nest();
        do_reset();
        set_ctl(1'b1, '1, 1'b1);
        pulse(24'(1) << 12);
        tick(1);
        check("R12 outer vec", 32'(vec), 32'(exp_vec(12)));
        accept();
        pulse(24'(1) << 8);
        tick(2);
        check("R10 mask after accept", 32'(irq), 0);
        write_mie(1'b1);
        tick(1);
        check("R12 nested irq", 32'(irq), 1);
        check("R12 nested vec", 32'(vec), 32'(exp_vec(8)));
        accept();
        pulse(24'(1) << 14);
        tick(2);
        check("R10 masked inside nested", 32'(irq), 0);
        reti = 1;
        tick(1);
        reti = 0;
        tick(1);
        check("R10 reti restores master", 32'(vec), 32'(exp_vec(14)));
        check("R10 reti irq", 32'(irq), 1);
    endtask

    task automatic t_stray_ack();
        do_reset();
        set_ctl(1'b1, ~(20'(1) << 2), 1'b1);
        pulse(24'(1) << 6);
        tick(1);
        check("R9 masked no irq", 32'(irq), 0);
        ack = 1;
        tick(1);
        ack = 0;
        en_we = 1; en_wd = '1;
        tick(1);
        en_we = 0;
        tick(1);
        check("R9 stray ack ignored irq", 32'(irq), 1);
        check("R9 stray ack ignored vec", 32'(vec), 32'(exp_vec(6)));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_map();
        t_mask();
        t_pin();
        t_nmi();
        t_prio();
        t_swclr();
        t_setwins();
        t_nest();
        t_stray_ack();
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule